// File: doc/BRIEF.md
# Pixel Output Data Formatter

This block sits at the output of a pixel digitiser. For every pixel strobe it captures a 12-bit converted sample, a 2-bit code naming the colour channel the sample came from, and two status flags: one for a converter input beyond its range, and one for sample/clamp positions that conflict with the chosen sampling mode. After a programmable delay it presents the sample on a 12-bit parallel bus with a data-valid qualifier.

Two output formats are offered. In full-width mode the whole sample goes out on all twelve lines in a single cycle. In byte mode each sample is split into two bytes sent on consecutive clocks on the upper eight lines. The first byte carries the top eight sample bits. The second byte carries the bottom four sample bits together with the two flags and the channel code. The delay is the sum of a coarse part, counted in whole pixel periods, and a fine part, counted in clocks. Strobes that arrive while an earlier byte pair is still going out wait in a small queue and are never lost.

Top module: `pix_out_fmt`

## Requirements
- R1: While reset is held and on the first cycles after it is released, `out_vld` is 0 and `out_data` is all zeros.
- R2: With `byte_mode` = 0, each sample produces exactly one cycle with `out_vld` = 1, and `out_data[11:0]` equals the sample on that cycle.
- R3: With `byte_mode` = 1, each sample produces exactly two beats on consecutive clocks, both with `out_vld` = 1. The first beat carries sample bits 11..4 on `out_data[11:4]`, with the MSB on bit 11.
- R4: The second byte-mode beat carries on `out_data[11:4]`, from bit 11 down to bit 4: sample bits 3,2,1,0, then `flag_timing`, `chan_code[1]`, `chan_code[0]`, `flag_range`.
- R5: On every byte-mode beat `out_data[3:0]` is 0.
- R6: Channel codes are red = 2'b00, green = 2'b01, blue = 2'b10. Code 2'b11 is never supplied with a strobe and never appears in bits [6:5] of a second beat. The code given with a strobe comes out unchanged.
- R7: The first beat of an isolated sample appears `dly_coarse`*PIX_PERIOD + `dly_fine` + 2 clock edges after the edge that samples `pix_vld`. The delay settings are held static while samples are in flight.
- R8: Strobes on consecutive clocks are all delivered in arrival order, with no drop and no interleaving of byte pairs. A byte-mode burst leaves the bus as one unbroken run of beats.
- R9: Whenever `out_vld` is 0, `out_data` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_vld | input | 1 | One-cycle strobe: a new sample is present |
| pix_data | input | 12 | Converted sample |
| chan_code | input | 2 | Colour channel code (00 red, 01 green, 10 blue) |
| flag_timing | input | 1 | Sample/clamp position conflict flag |
| flag_range | input | 1 | Converter over-range flag |
| byte_mode | input | 1 | 1: two bytes per sample, 0: one 12-bit word |
| dly_coarse | input | 2 | Extra delay in whole pixel periods (0..3) |
| dly_fine | input | 2 | Extra delay in clocks (0..3) |
| out_data | output | 12 | Output bus |
| out_vld | output | 1 | Output beat valid |

## Verification
On every cycle the assertions check that the bus is zero while idle, that byte-mode beats keep the low nibble clear, that a first byte is always followed by its second byte and every second byte by its first, that the channel code is legal at both input and output, and that the queue is never written while full. The exact field packing against a model, the byte order, the latency for each coarse and fine setting, and the order and count of samples in back-to-back bursts can only be shown by the bench's directed scenarios, which capture every beat and compare it with values computed from the requirements.

// File: rtl/pof_pkg.sv
package pof_pkg;
   // number of non-sample bits packed beside the low sample nibble
   localparam int FLAG_W = 4;
   // channel code values
   localparam logic [1:0] CODE_RED   = 2'b00;
   localparam logic [1:0] CODE_GREEN = 2'b01;
   localparam logic [1:0] CODE_BLUE  = 2'b10;
   localparam logic [1:0] CODE_BAD   = 2'b11;
endpackage

// File: rtl/pof_delay_line.sv
module pof_delay_line #(
   parameter int WORD_W = 16,
   parameter int NSTG   = 16,
   parameter int SEL_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_vld,
   input  logic [WORD_W-1:0] in_word,
   input  logic [SEL_W-1:0]  sel,
   output logic              tap_vld,
   output logic [WORD_W-1:0] tap_word
);
   logic [NSTG-1:0]   stg_v;
   logic [WORD_W-1:0] stg_w [NSTG];

   for (genvar i = 0; i < NSTG; i++) begin : g_stg
      if (i == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (!rst_n) stg_v[0] <= 1'b0;
            else        stg_v[0] <= in_vld;
            stg_w[0] <= in_word;
         end
      end else begin : g_body
         always_ff @(posedge clk) begin
            if (!rst_n) stg_v[i] <= 1'b0;
            else        stg_v[i] <= stg_v[i-1];
            stg_w[i] <= stg_w[i-1];
         end
      end
   end

   assign tap_vld  = stg_v[sel];
   assign tap_word = stg_w[sel];
endmodule

// File: rtl/pof_queue.sv
module pof_queue #(
   parameter int WORD_W = 16,
   parameter int DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [WORD_W-1:0] push_word,
   input  logic              pop,
   output logic [WORD_W-1:0] head_word,
   output logic              head_vld,
   output logic              full
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (1 << PTR_W) != DEPTH) begin : g_bad_depth
      $error("pof_queue: DEPTH must be a power of two, at least 2");
   end

   logic [WORD_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wptr, rptr;
   logic [CNT_W-1:0]  cnt;
   logic              do_push, do_pop;

   assign head_vld  = (cnt != '0);
   assign full      = (cnt == CNT_W'(DEPTH));
   assign do_pop    = pop && head_vld;
   assign do_push   = push && (!full || do_pop);
   assign head_word = mem[rptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= push_word;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (do_push) wptr <= wptr + 1'b1;
         if (do_pop)  rptr <= rptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/pof_serializer.sv
module pof_serializer #(
   parameter int DATA_W = 12,
   parameter int BYTE_W = 8,
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_mode,
   input  logic              head_vld,
   input  logic [WORD_W-1:0] head_word,
   output logic              pop,
   output logic [DATA_W-1:0] out_data,
   output logic              out_vld,
   output logic              beat_mux,
   output logic              beat_second
);
   localparam int PAD_W = DATA_W - BYTE_W;

   logic [BYTE_W-1:0] lo_q;
   logic [DATA_W-1:0] first_beat;
   logic              need_second;

   assign need_second = out_vld && beat_mux && !beat_second;
   assign pop         = head_vld && !need_second;

   // first beat: upper byte padded, or the full sample
   if (PAD_W > 0) begin : g_pad
      assign first_beat = byte_mode ? {head_word[WORD_W-1 -: BYTE_W], {PAD_W{1'b0}}}
                                    : head_word[WORD_W-1 -: DATA_W];
   end else begin : g_nopad
      assign first_beat = byte_mode ? head_word[WORD_W-1 -: BYTE_W]
                                    : head_word[WORD_W-1 -: DATA_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_data    <= '0;
         out_vld     <= 1'b0;
         beat_mux    <= 1'b0;
         beat_second <= 1'b0;
         lo_q        <= '0;
      end else if (need_second) begin
         out_data    <= DATA_W'({lo_q, {PAD_W{1'b0}}});
         beat_second <= 1'b1;
      end else if (head_vld) begin
         out_data    <= first_beat;
         out_vld     <= 1'b1;
         beat_mux    <= byte_mode;
         beat_second <= 1'b0;
         lo_q        <= head_word[BYTE_W-1:0];
      end else begin
         out_data    <= '0;
         out_vld     <= 1'b0;
         beat_mux    <= 1'b0;
         beat_second <= 1'b0;
      end
   end
endmodule

// File: rtl/pix_out_fmt.sv
module pix_out_fmt
   import pof_pkg::*;
#(
   parameter int DATA_W     = 12,
   parameter int BYTE_W     = 8,
   parameter int PIX_PERIOD = 4,
   parameter int QDEPTH     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pix_vld,
   input  logic [DATA_W-1:0] pix_data,
   input  logic [1:0]        chan_code,
   input  logic              flag_timing,
   input  logic              flag_range,
   input  logic              byte_mode,
   input  logic [1:0]        dly_coarse,
   input  logic [1:0]        dly_fine,
   output logic [DATA_W-1:0] out_data,
   output logic              out_vld
);
   localparam int WORD_W  = DATA_W + FLAG_W;
   localparam int MAX_DLY = 3 * PIX_PERIOD + 3;
   localparam int NSTG    = MAX_DLY + 1;
   localparam int SEL_W   = $clog2(NSTG);

   if (WORD_W != 2 * BYTE_W) begin : g_bad_width
      $error("pix_out_fmt: sample plus flags must fill exactly two bytes");
   end
   if (PIX_PERIOD < 1) begin : g_bad_period
      $error("pix_out_fmt: PIX_PERIOD must be at least 1");
   end

   logic [WORD_W-1:0] in_word, tap_word, q_head;
   logic [SEL_W-1:0]  dly_sel;
   logic              tap_vld, q_head_vld, q_full, ser_pop;
   logic              beat_mux, beat_second;

   // packed word: sample, timing flag, channel code, range flag
   assign in_word = {pix_data, flag_timing, chan_code, flag_range};
   assign dly_sel = SEL_W'(int'(dly_coarse) * PIX_PERIOD + int'(dly_fine));

   pof_delay_line #(.WORD_W(WORD_W), .NSTG(NSTG), .SEL_W(SEL_W)) u_dly (
      .clk(clk), .rst_n(rst_n), .in_vld(pix_vld), .in_word(in_word),
      .sel(dly_sel), .tap_vld(tap_vld), .tap_word(tap_word)
   );

   pof_queue #(.WORD_W(WORD_W), .DEPTH(QDEPTH)) u_q (
      .clk(clk), .rst_n(rst_n), .push(tap_vld), .push_word(tap_word),
      .pop(ser_pop), .head_word(q_head), .head_vld(q_head_vld), .full(q_full)
   );

   pof_serializer #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_ser (
      .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .head_vld(q_head_vld),
      .head_word(q_head), .pop(ser_pop), .out_data(out_data), .out_vld(out_vld),
      .beat_mux(beat_mux), .beat_second(beat_second)
   );
endmodule

// File: rtl/pix_out_fmt_chk.sv
module pix_out_fmt_chk
   import pof_pkg::*;
#(
   parameter int DATA_W = 12,
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pix_vld,
   input logic [1:0]        chan_code,
   input logic [DATA_W-1:0] out_data,
   input logic              out_vld,
   input logic              beat_mux,
   input logic              beat_second,
   input logic              q_push,
   input logic              q_full,
   input logic              q_pop
);
   localparam int PAD_W = DATA_W - BYTE_W;

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !out_vld |-> out_data == '0) else $error("idle bus not zero"); // R9
   AST_NIBBLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && beat_mux) |-> out_data[PAD_W-1:0] == '0) else $error("low nibble set"); // R5
   AST_PAIR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && beat_mux && !beat_second) |=> (out_vld && beat_mux && beat_second)) else $error("second byte missing"); // R3
   AST_SECOND_HAS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && beat_second) |-> $past(out_vld && beat_mux && !beat_second)) else $error("orphan second byte"); // R3
   AST_CODE_OUT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && beat_second) |-> out_data[PAD_W+2:PAD_W+1] != CODE_BAD) else $error("code 11 emitted"); // R6
   AST_CODE_IN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      pix_vld |-> chan_code != CODE_BAD) else $error("code 11 supplied"); // R6
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      q_push |-> (!q_full || q_pop)) else $error("queue overflow"); // R8
endmodule

bind pix_out_fmt pix_out_fmt_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .pix_vld(pix_vld), .chan_code(chan_code),
   .out_data(out_data), .out_vld(out_vld), .beat_mux(beat_mux),
   .beat_second(beat_second), .q_push(tap_vld), .q_full(q_full), .q_pop(ser_pop)
);

// File: tb/pix_out_fmt_bench.sv
`timescale 1ns/1ps
module pix_out_fmt_bench;
   localparam int PER = 4;
   localparam logic [1:0] RED = 2'b00, GREEN = 2'b01, BLUE = 2'b10;

   logic        clk = 1'b0;
   logic        rst_n, pix_vld, flag_timing, flag_range, byte_mode;
   logic [11:0] pix_data, out_data;
   logic [1:0]  chan_code, dly_coarse, dly_fine;
   logic        out_vld;

   always #4 clk = ~clk;

   pix_out_fmt #(.PIX_PERIOD(PER)) u_pix_out_fmt (
      .clk(clk), .rst_n(rst_n), .pix_vld(pix_vld), .pix_data(pix_data),
      .chan_code(chan_code), .flag_timing(flag_timing), .flag_range(flag_range),
      .byte_mode(byte_mode), .dly_coarse(dly_coarse), .dly_fine(dly_fine),
      .out_data(out_data), .out_vld(out_vld)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int checks = 0, errors = 0;
   int nbeat = 0, idle_bad = 0;
   logic [11:0] bd [64];
   int          bc [64];

   always @(negedge clk) begin
      if (out_vld) begin
         if (nbeat < 64) begin
            bd[nbeat] = out_data;
            bc[nbeat] = cyc;
         end
         nbeat++;
      end else if (out_data != 12'h000) idle_bad++;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [11:0] byte_a(input logic [11:0] d);
      return {d[11:4], 4'b0000};
   endfunction
   function automatic logic [11:0] byte_b(input logic [11:0] d, input logic tv,
                                          input logic [1:0] cc, input logic ov);
      return {d[3:0], tv, cc[1], cc[0], ov, 4'b0000};
   endfunction

   task automatic drive(input logic [11:0] d, input logic tv, input logic [1:0] cc, input logic ov);
      pix_data = d; flag_timing = tv; chan_code = cc; flag_range = ov; pix_vld = 1'b1;
   endtask

   task automatic t_reset();
      rst_n = 1'b0; pix_vld = 1'b0; pix_data = '0; chan_code = RED;
      flag_timing = 0; flag_range = 0; byte_mode = 0; dly_coarse = 0; dly_fine = 0;
      repeat (4) @(negedge clk);
      chk(out_vld == 1'b0, "R1 valid in reset", int'(out_vld), 0);
      chk(out_data == 12'h000, "R1 data in reset", int'(out_data), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(out_vld == 1'b0 && out_data == 12'h000, "R1 after reset", int'(out_data), 0);
   endtask

   task automatic t_full_one(input logic [11:0] d, input logic tv, input logic [1:0] cc,
                             input logic ov, input int co, input int fi);
      int s;
      @(negedge clk); byte_mode = 0; dly_coarse = 2'(co); dly_fine = 2'(fi); nbeat = 0;
      @(negedge clk); drive(d, tv, cc, ov); s = cyc + 1;
      @(negedge clk); pix_vld = 1'b0;
      repeat (25) @(negedge clk);
      chk(nbeat == 1, "R2 beat count", nbeat, 1);
      chk(bd[0] == d, "R2 word", int'(bd[0]), int'(d));
      chk(bc[0] == s + co * PER + fi + 2, "R7 latency full", bc[0] - s, co * PER + fi + 2);
   endtask

   task automatic t_mux_one(input logic [11:0] d, input logic tv, input logic [1:0] cc,
                            input logic ov, input int co, input int fi);
      int s;
      @(negedge clk); byte_mode = 1; dly_coarse = 2'(co); dly_fine = 2'(fi); nbeat = 0;
      @(negedge clk); drive(d, tv, cc, ov); s = cyc + 1;
      @(negedge clk); pix_vld = 1'b0;
      repeat (25) @(negedge clk);
      chk(nbeat == 2, "R3 beat count", nbeat, 2);
      chk(bd[0] == byte_a(d), "R3 first byte", int'(bd[0]), int'(byte_a(d)));
      chk(bc[1] == bc[0] + 1, "R3 consecutive beats", bc[1] - bc[0], 1);
      chk(bd[1] == byte_b(d, tv, cc, ov), "R4 second byte", int'(bd[1]), int'(byte_b(d, tv, cc, ov)));
      chk((bd[0][3:0] | bd[1][3:0]) == 4'h0, "R5 low nibble", int'(bd[0][3:0] | bd[1][3:0]), 0);
      chk(bd[1][6:5] == cc, "R6 channel code", int'(bd[1][6:5]), int'(cc));
      chk(bc[0] == s + co * PER + fi + 2, "R7 latency byte", bc[0] - s, co * PER + fi + 2);
   endtask

   task automatic t_burst(input logic mode, input int n, input int co, input int fi);
      int s, k, nexp;
      @(negedge clk); byte_mode = mode; dly_coarse = 2'(co); dly_fine = 2'(fi); nbeat = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         drive(12'h3A5 + 12'(i * 12'h2D7), i[0], 2'(i % 3), i[1]);
         if (i == 0) s = cyc + 1;
      end
      @(negedge clk); pix_vld = 1'b0;
      repeat (40) @(negedge clk);
      nexp = mode ? 2 * n : n;
      chk(nbeat == nexp, "R8 burst beat count", nbeat, nexp);
      chk(bc[0] == s + co * PER + fi + 2, "R7 burst latency", bc[0] - s, co * PER + fi + 2);
      chk(bc[nexp-1] == bc[0] + nexp - 1, "R8 unbroken run", bc[nexp-1] - bc[0], nexp - 1);
      k = 0;
      for (int i = 0; i < n; i++) begin
         logic [11:0] d;
         d = 12'h3A5 + 12'(i * 12'h2D7);
         if (mode) begin
            chk(bd[k] == byte_a(d), "R8 order first byte", int'(bd[k]), int'(byte_a(d)));
            chk(bd[k+1] == byte_b(d, i[0], 2'(i % 3), i[1]), "R8 order second byte",
                int'(bd[k+1]), int'(byte_b(d, i[0], 2'(i % 3), i[1])));
            k += 2;
         end else begin
            chk(bd[k] == d, "R8 order word", int'(bd[k]), int'(d));
            k += 1;
         end
      end
   endtask

   initial begin
      #(100000 * 8);
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      t_reset();
      t_full_one(12'hABC, 1'b0, RED, 1'b0, 0, 0);
      t_full_one(12'h123, 1'b1, GREEN, 1'b1, 2, 3);
      t_mux_one(12'hF0F, 1'b1, BLUE, 1'b0, 0, 0);
      t_mux_one(12'h5A3, 1'b0, GREEN, 1'b1, 1, 2);
      t_mux_one(12'h001, 1'b1, RED, 1'b1, 3, 3);
      t_mux_one(12'hFFF, 1'b0, BLUE, 1'b0, 3, 0);
      t_burst(1'b1, 4, 0, 1);
      t_burst(1'b0, 4, 2, 0);
      t_burst(1'b1, 3, 1, 3);
      chk(idle_bad == 0, "R9 idle bus zero", idle_bad, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule